// File: doc/BRIEF.md
# CPU Bus Fault Monitor

This block sits beside the CPU's port on a shared system bus and watches every transfer that passes through that port. It looks for four kinds of fault. The first is a request whose reply never comes back. The second is a bad parity bit on the 8-bit system header (destination, source and command fields), checked both on traffic the CPU sends and on traffic it receives. The third is a bad parity bit on a 16-bit data word arriving from memory. The fourth is a memory access to a word address above the installed memory size.

Each detected fault does three things on the next clock edge. It raises a one-cycle interrupt request carrying a fixed identification code. It sets a sticky bit in a status vector. When the fault is an inbound header parity error on traffic involving the I/O processor, it also pulses a transfer-error line toward the requesting device. The CPU and the I/O processor answer to the same module number, so a corrupted inbound transfer is reported at the CPU whichever of the two it was meant for.

A data parity fault only reports. It holds nothing back and aborts nothing, so the instruction in flight runs to completion. The reply timeout length and the installed memory size are parameters.

Top module: `bus_fault_mon`

## Requirements
- R1: During and right after reset, `irq_valid` and `xfer_err` are 0, `irq_code` is 0 and `fault_status` is 0.
- R2: An inbound transfer (`rx_valid`=1) whose 8-bit header plus `rx_hdr_par` holds an even number of ones is a system parity fault. After the next clock edge, `irq_valid`=1, `irq_code`=4'h5 and `fault_status[1]`=1. An odd count is no fault.
- R3: An outbound transfer (`tx_valid`=1) is checked by the same odd-parity rule over `tx_hdr` and `tx_hdr_par`, and raises the same code 4'h5 and `fault_status[1]`.
- R4: `xfer_err` pulses for one cycle, after the edge that sampled it, only for an inbound header parity fault where `rx_for_iop`=1 or `iop_wait`=1. An outbound parity fault never asserts it.
- R5: When `rx_valid`=1 and `rx_has_data`=1, an even number of ones across `rx_data` and `rx_data_par` raises code 4'h6 and sets `fault_status[2]`. With `rx_has_data`=0 the data bits are ignored.
- R6: When `tx_valid`=1 and `tx_mem`=1, a `tx_addr` at or above MEM_WORDS raises code 4'h2 and sets `fault_status[3]`. An access below the limit, or a transfer with `tx_mem`=0, raises nothing.
- R7: A `req_issue` pulse arms a timer. If no reply arrives, the timeout raises code 4'h3 and sets `fault_status[0]` after exactly TIMEOUT_CYC further clock edges. A reply is a transfer with `rx_valid`=1, `rx_for_iop`=0 and good header parity.
- R8: A reply sampled on the final timer edge cancels the timeout. A new `req_issue` while the timer is armed reloads it to the full TIMEOUT_CYC.
- R9: When several faults occur in one cycle, every matching status bit is set and `irq_code` shows the highest of them, in this order: timeout, system parity, data parity, illegal address.
- R10: Status bits stay set until a 1 is written to the same bit of `status_clr`. If a bit is set and cleared in the same cycle, the set wins.
- R11: `irq_valid` is high for exactly the cycles that follow an edge at which at least one fault was detected. Otherwise it is 0, with `irq_code`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_issue | input | 1 | CPU issued a request that expects a reply |
| rx_valid | input | 1 | Inbound transfer present at the shared module number |
| rx_hdr | input | 8 | Inbound system header word |
| rx_hdr_par | input | 1 | Inbound header parity bit |
| rx_has_data | input | 1 | Inbound transfer carries a memory data word |
| rx_data | input | 16 | Inbound data word |
| rx_data_par | input | 1 | Inbound data parity bit |
| rx_for_iop | input | 1 | Inbound transfer is addressed to the I/O processor |
| iop_wait | input | 1 | I/O processor is waiting for data |
| tx_valid | input | 1 | Outbound transfer driven by the CPU |
| tx_hdr | input | 8 | Outbound system header word |
| tx_hdr_par | input | 1 | Outbound header parity bit |
| tx_mem | input | 1 | Outbound transfer is a memory word access |
| tx_addr | input | 16 | Outbound memory word address |
| status_clr | input | 4 | Write-one-to-clear strobe, one bit per status bit |
| irq_valid | output | 1 | Interrupt request pulse |
| irq_code | output | 4 | Fault identification code |
| xfer_err | output | 1 | Transfer error toward the requesting device |
| fault_status | output | 4 | Sticky status: [0] timeout, [1] system parity, [2] data parity, [3] illegal address |

## Verification
Both header checks are swept over all 256 header values with both parity bits. Each sweep separates even from odd ones counts, and the inbound sweep also varies the I/O processor flags, which shows that the transfer error follows only inbound faults. The data check uses every one-hot and two-hot word with both parity bits, plus a pass with the data flag low, which shows that the flag gates the check. Addresses are swept across the whole space and densely around the memory limit. All fifteen mixes of simultaneous faults are then applied, which tells the priority order apart from the status accumulation. Separate runs of the timer show where it fires, a last-edge cancel and a mid-count reload.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

    // fault slot positions in the status vector; order is also priority
    localparam int unsigned F_TMO   = 0;
    localparam int unsigned F_SYS   = 1;
    localparam int unsigned F_DAT   = 2;
    localparam int unsigned F_ADR   = 3;
    localparam int unsigned N_FAULT = 4;

    typedef enum logic [3:0] {
        CODE_NONE = 4'h0,
        CODE_ADR  = 4'h2,
        CODE_TMO  = 4'h3,
        CODE_SYS  = 4'h5,
        CODE_DAT  = 4'h6
    } fault_code_e;

    typedef struct packed {
        logic adr;
        logic dat;
        logic sys;
        logic tmo;
    } fault_vec_t;

    function automatic fault_code_e slot_code(input int unsigned slot);
        case (slot)
            F_TMO:   return CODE_TMO;
            F_SYS:   return CODE_SYS;
            F_DAT:   return CODE_DAT;
            F_ADR:   return CODE_ADR;
            default: return CODE_NONE;
        endcase
    endfunction

    function automatic int unsigned code_slot(input logic [3:0] code);
        case (code)
            CODE_TMO: return F_TMO;
            CODE_SYS: return F_SYS;
            CODE_DAT: return F_DAT;
            default:  return F_ADR;
        endcase
    endfunction

endpackage

// File: rtl/bfm_parity_chk.sv
module bfm_parity_chk #(
    parameter int unsigned W = 8
) (
    input  logic         en,
    input  logic [W-1:0] word,
    input  logic         par,
    output logic         err
);
    // odd parity: a clean word plus its parity bit holds an odd ones count
    logic ones_odd;

    assign ones_odd = ^{word, par};
    assign err      = en & ~ones_odd;

endmodule

// File: rtl/bfm_reply_timer.sv
module bfm_reply_timer #(
    parameter int unsigned TIMEOUT_CYC = 46000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic reply,
    output logic expired
);
    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(TIMEOUT_CYC);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic          last;

    assign last    = busy_q && (cnt_q == CW'(1));
    assign expired = last && !reply && !arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (arm) begin
            busy_q <= 1'b1;
            cnt_q  <= LOAD;
        end else if (busy_q && (reply || last)) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q - CW'(1);
        end
    end

    AST_TMO_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LOAD); // R7

    AST_TMO_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        expired |=> !busy_q); // R7

endmodule

// File: rtl/bfm_fault_arb.sv
module bfm_fault_arb
    import bfm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  fault_vec_t          faults,
    input  logic [N_FAULT-1:0]  clr,
    output logic                irq_valid,
    output logic [3:0]          irq_code,
    output logic [N_FAULT-1:0]  status
);
    logic [N_FAULT-1:0] hit;
    logic [N_FAULT-1:0] status_q;
    fault_code_e        code_d;
    logic               irq_q;
    logic [3:0]         code_q;

    assign hit = faults;

    // lowest slot index has highest priority
    always_comb begin
        code_d = CODE_NONE;
        for (int i = N_FAULT - 1; i >= 0; i--) begin
            if (hit[i]) code_d = slot_code(i);
        end
    end

    generate
        for (genvar g = 0; g < N_FAULT; g++) begin : g_stat
            always_ff @(posedge clk) begin
                if (rst)         status_q[g] <= 1'b0;
                else if (hit[g]) status_q[g] <= 1'b1;
                else if (clr[g]) status_q[g] <= 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= 1'b0;
            code_q <= CODE_NONE;
        end else begin
            irq_q  <= |hit;
            code_q <= code_d;
        end
    end

    assign irq_valid = irq_q;
    assign irq_code  = code_q;
    assign status    = status_q;

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (($past(status_q) & ~$past(clr)) & ~status_q) == '0); // R10

    AST_IRQ_HAS_STATUS: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> status_q[code_slot(code_q)]); // R11

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (code_q == CODE_TMO || code_q == CODE_SYS ||
                   code_q == CODE_DAT || code_q == CODE_ADR)); // R9

    AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !irq_q |-> code_q == CODE_NONE); // R11

endmodule

// File: rtl/bus_fault_mon.sv
module bus_fault_mon
    import bfm_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 46000,
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned MEM_WORDS   = 49152
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_issue,
    input  logic              rx_valid,
    input  logic [7:0]        rx_hdr,
    input  logic              rx_hdr_par,
    input  logic              rx_has_data,
    input  logic [15:0]       rx_data,
    input  logic              rx_data_par,
    input  logic              rx_for_iop,
    input  logic              iop_wait,
    input  logic              tx_valid,
    input  logic [7:0]        tx_hdr,
    input  logic              tx_hdr_par,
    input  logic              tx_mem,
    input  logic [ADDR_W-1:0] tx_addr,
    input  logic [3:0]        status_clr,
    output logic              irq_valid,
    output logic [3:0]        irq_code,
    output logic              xfer_err,
    output logic [3:0]        fault_status
);
    localparam logic [ADDR_W:0] ADDR_LIMIT = (ADDR_W + 1)'(MEM_WORDS);

    logic       rx_hdr_bad;
    logic       tx_hdr_bad;
    logic       rx_dat_bad;
    logic       addr_bad;
    logic       reply;
    logic       tmo_hit;
    logic       xfer_q;
    fault_vec_t faults;

    bfm_parity_chk #(.W(8)) u_rx_hdr_chk (
        .en   (rx_valid),
        .word (rx_hdr),
        .par  (rx_hdr_par),
        .err  (rx_hdr_bad)
    );

    bfm_parity_chk #(.W(8)) u_tx_hdr_chk (
        .en   (tx_valid),
        .word (tx_hdr),
        .par  (tx_hdr_par),
        .err  (tx_hdr_bad)
    );

    bfm_parity_chk #(.W(16)) u_rx_dat_chk (
        .en   (rx_valid && rx_has_data),
        .word (rx_data),
        .par  (rx_data_par),
        .err  (rx_dat_bad)
    );

    assign addr_bad = tx_valid && tx_mem && ({1'b0, tx_addr} >= ADDR_LIMIT);
    assign reply    = rx_valid && !rx_for_iop && !rx_hdr_bad;

    bfm_reply_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .arm     (req_issue),
        .reply   (reply),
        .expired (tmo_hit)
    );

    always_comb begin
        faults.tmo = tmo_hit;
        faults.sys = rx_hdr_bad || tx_hdr_bad;
        faults.dat = rx_dat_bad;
        faults.adr = addr_bad;
    end

    bfm_fault_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .faults    (faults),
        .clr       (status_clr),
        .irq_valid (irq_valid),
        .irq_code  (irq_code),
        .status    (fault_status)
    );

    // shared module number: a corrupted inbound transfer touching the IOP
    // side is also reported back to the requester
    always_ff @(posedge clk) begin
        if (rst) xfer_q <= 1'b0;
        else     xfer_q <= rx_hdr_bad && (rx_for_iop || iop_wait);
    end

    assign xfer_err = xfer_q;

    AST_XFER_NEEDS_SYSPAR: assert property (@(posedge clk) disable iff (rst)
        xfer_err |-> (fault_status[F_SYS] && irq_valid)); // R4

    AST_XFER_INBOUND_ONLY: assert property (@(posedge clk) disable iff (rst)
        (tx_hdr_bad && !rx_valid) |=> !xfer_err); // R4

    AST_ADDR_FAULT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        addr_bad |=> (irq_valid && fault_status[F_ADR])); // R6

endmodule

// File: tb/bus_fault_mon_bench.sv
module bus_fault_mon_bench;

    localparam int unsigned T   = 12;
    localparam int unsigned MEM = 40000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_issue, rx_valid, rx_hdr_par, rx_has_data, rx_data_par;
    logic        rx_for_iop, iop_wait, tx_valid, tx_hdr_par, tx_mem;
    logic [7:0]  rx_hdr, tx_hdr;
    logic [15:0] rx_data, tx_addr;
    logic [3:0]  status_clr;
    logic        irq_valid, xfer_err;
    logic [3:0]  irq_code, fault_status;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    bus_fault_mon #(.TIMEOUT_CYC(T), .ADDR_W(16), .MEM_WORDS(MEM)) u_bus_fault_mon (
        .clk(clk), .rst(rst), .req_issue(req_issue), .rx_valid(rx_valid),
        .rx_hdr(rx_hdr), .rx_hdr_par(rx_hdr_par), .rx_has_data(rx_has_data),
        .rx_data(rx_data), .rx_data_par(rx_data_par), .rx_for_iop(rx_for_iop),
        .iop_wait(iop_wait), .tx_valid(tx_valid), .tx_hdr(tx_hdr),
        .tx_hdr_par(tx_hdr_par), .tx_mem(tx_mem), .tx_addr(tx_addr),
        .status_clr(status_clr), .irq_valid(irq_valid), .irq_code(irq_code),
        .xfer_err(xfer_err), .fault_status(fault_status)
    );

    function automatic logic okpar8(input logic [7:0] w);
        return ~^w;
    endfunction

    function automatic logic okpar16(input logic [15:0] w);
        return ~^w;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        req_issue = 0; rx_valid = 0; rx_hdr = 8'h00; rx_hdr_par = 1;
        rx_has_data = 0; rx_data = 0; rx_data_par = 1; rx_for_iop = 0;
        iop_wait = 0; tx_valid = 0; tx_hdr = 8'h00; tx_hdr_par = 1;
        tx_mem = 0; tx_addr = 0; status_clr = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_irq(input bit v, input logic [3:0] c, input string req);
        check(irq_valid == v, req, irq_valid, v);
        check(irq_code == (v ? c : 4'h0), req, irq_code, v ? c : 4'h0);
    endtask

    task automatic clear_all();
        idle();
        status_clr = 4'hF;
        step();
        idle();
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit ok;
        idle();
        rst = 1;
        step(); step();
        // R1 reset state
        check(irq_valid == 0 && xfer_err == 0 && irq_code == 0 && fault_status == 0,
              "R1", {irq_valid, xfer_err, irq_code, fault_status}, 0);
        rst = 0;
        step();
        check(irq_valid == 0 && fault_status == 0, "R1", fault_status, 0);

        // R2 R4: inbound header sweep
        ok = 1;
        for (int h = 0; h < 256; h++) begin
            for (int p = 0; p < 2; p++) begin
                bit bad, xe;
                idle();
                rx_valid = 1; rx_hdr = 8'(h); rx_hdr_par = p[0];
                rx_for_iop = h[0]; iop_wait = h[1];
                bad = (^{8'(h), p[0]}) == 1'b0;
                xe  = bad && (h[0] || h[1]);
                step();
                if (irq_valid != bad || irq_code != (bad ? 4'h5 : 4'h0)) begin
                    ok = 0;
                    check(0, "R2", {irq_valid, irq_code}, {bad, bad ? 4'h5 : 4'h0});
                end
                if (xfer_err != xe) begin
                    ok = 0;
                    check(0, "R4", xfer_err, xe);
                end
            end
        end
        check(ok, "R2 sweep", 0, 0);
        check(fault_status == 4'b0010, "R2", fault_status, 4'b0010);
        clear_all();
        step();
        check(fault_status == 0, "R10", fault_status, 0);

        // R3 R4: outbound header sweep
        ok = 1;
        for (int h = 0; h < 256; h++) begin
            for (int p = 0; p < 2; p++) begin
                bit bad;
                idle();
                tx_valid = 1; tx_mem = 1; tx_addr = 16'd5;
                tx_hdr = 8'(h); tx_hdr_par = p[0]; iop_wait = 1;
                bad = (^{8'(h), p[0]}) == 1'b0;
                step();
                if (irq_valid != bad || irq_code != (bad ? 4'h5 : 4'h0)) begin
                    ok = 0;
                    check(0, "R3", {irq_valid, irq_code}, {bad, bad ? 4'h5 : 4'h0});
                end
                if (xfer_err != 0) begin
                    ok = 0;
                    check(0, "R4 outbound", xfer_err, 0);
                end
            end
        end
        check(ok, "R3 sweep", 0, 0);
        check(fault_status == 4'b0010, "R3", fault_status, 4'b0010);
        clear_all();

        // R5: data parity over one-hot and two-hot words
        ok = 1;
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                for (int p = 0; p < 2; p++) begin
                    logic [15:0] w;
                    bit bad;
                    w = (16'h1 << i) | (16'h1 << j);
                    idle();
                    rx_valid = 1; rx_for_iop = 1; rx_hdr = 8'h3C;
                    rx_hdr_par = okpar8(8'h3C); rx_has_data = 1;
                    rx_data = w; rx_data_par = p[0];
                    bad = (^{w, p[0]}) == 1'b0;
                    step();
                    if (irq_valid != bad || irq_code != (bad ? 4'h6 : 4'h0) || xfer_err) begin
                        ok = 0;
                        check(0, "R5", {irq_valid, irq_code}, {bad, bad ? 4'h6 : 4'h0});
                    end
                end
            end
        end
        check(ok, "R5 sweep", 0, 0);
        check(fault_status == 4'b0100, "R5", fault_status, 4'b0100);
        clear_all();
        idle();
        rx_valid = 1; rx_hdr_par = okpar8(8'h00); rx_has_data = 0;
        rx_data = 16'h0000; rx_data_par = 0;
        step();
        expect_irq(0, 0, "R5 no data flag");
        check(fault_status == 0, "R5 no data flag", fault_status, 0);

        // R6: address sweep
        ok = 1;
        for (int a = 0; a < 256 + 24; a++) begin
            logic [15:0] ad;
            bit bad;
            ad = (a < 256) ? 16'(a * 256 + (a % 7)) : 16'(MEM - 12 + (a - 256));
            idle();
            tx_valid = 1; tx_mem = 1; tx_addr = ad;
            tx_hdr = 8'h81; tx_hdr_par = okpar8(8'h81);
            bad = int'(ad) >= MEM;
            step();
            if (irq_valid != bad || irq_code != (bad ? 4'h2 : 4'h0)) begin
                ok = 0;
                check(0, "R6", {ad, irq_valid}, {ad, bad});
            end
        end
        check(ok, "R6 sweep", 0, 0);
        check(fault_status == 4'b1000, "R6", fault_status, 4'b1000);
        clear_all();
        idle();
        tx_valid = 1; tx_mem = 0; tx_addr = 16'hFFFF; tx_hdr_par = okpar8(8'h00);
        step();
        expect_irq(0, 0, "R6 non-memory");
        idle();
        tx_valid = 1; tx_mem = 1; tx_addr = 16'(MEM - 1); tx_hdr_par = okpar8(8'h00);
        step();
        expect_irq(0, 0, "R6 last word");

        // R7 R11: timeout fires after exactly T edges, one pulse
        idle(); req_issue = 1; step(); idle();
        for (int k = 1; k <= T; k++) begin
            step();
            expect_irq(k == T, 4'h3, "R7");
        end
        step();
        expect_irq(0, 0, "R11 pulse");
        check(fault_status == 4'b0001, "R7", fault_status, 4'b0001);
        clear_all();

        // R8: reply on last edge cancels
        idle(); req_issue = 1; step(); idle();
        for (int k = 1; k < T; k++) begin
            step();
            expect_irq(0, 0, "R8 cancel");
        end
        rx_valid = 1; rx_hdr = 8'h12; rx_hdr_par = okpar8(8'h12);
        step(); idle();
        expect_irq(0, 0, "R8 cancel last");
        for (int k = 0; k < T + 2; k++) begin
            step();
            expect_irq(0, 0, "R8 after cancel");
        end

        // R8: reload while armed
        idle(); req_issue = 1; step(); idle();
        for (int k = 1; k < T; k++) step();
        req_issue = 1; step(); idle();
        expect_irq(0, 0, "R8 reload");
        for (int k = 1; k <= T; k++) begin
            step();
            expect_irq(k == T, 4'h3, "R8 reload");
        end
        clear_all();

        // R9: all mixes of simultaneous faults
        for (int m = 1; m < 16; m++) begin
            logic [3:0] ec;
            ec = m[0] ? 4'h3 : m[1] ? 4'h5 : m[2] ? 4'h6 : 4'h2;
            if (m[0]) begin
                idle(); req_issue = 1; step(); idle();
                for (int k = 1; k < T; k++) step();
            end
            idle();
            if (m[1] || m[3]) begin
                tx_valid = 1; tx_hdr = 8'h55;
                tx_hdr_par = m[1] ? ~okpar8(8'h55) : okpar8(8'h55);
                tx_mem = m[3]; tx_addr = m[3] ? 16'hFFF0 : 16'h0;
            end
            if (m[2]) begin
                rx_valid = 1; rx_for_iop = 1; rx_hdr_par = okpar8(8'h00);
                rx_has_data = 1; rx_data = 16'h00F0; rx_data_par = ~okpar16(16'h00F0);
            end
            step(); idle();
            expect_irq(1, ec, "R9");
            check(fault_status == 4'(m), "R9 status", fault_status, m);
            check(xfer_err == 0, "R9 xfer", xfer_err, 0);
            clear_all();
        end

        // R10: set wins over clear, clear is per bit
        idle();
        tx_valid = 1; tx_hdr_par = ~okpar8(8'h00); tx_mem = 1; tx_addr = 16'hFFFF;
        status_clr = 4'b1010;
        step(); idle();
        check(fault_status == 4'b1010, "R10 set wins", fault_status, 4'b1010);
        status_clr = 4'b0010; step(); idle();
        check(fault_status == 4'b1000, "R10 partial", fault_status, 4'b1000);
        step();
        check(fault_status == 4'b1000, "R10 sticky", fault_status, 4'b1000);
        expect_irq(0, 0, "R11 idle");
        clear_all();
        step();
        check(fault_status == 0, "R10 cleared", fault_status, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule